// File: doc/BRIEF.md
# Paired DMA Channel Enable Arbiter

This block owns the configuration and enable state of two DMA channels that serve a pair of peripheral slots, A and B. Software programs a control register per channel (transfer width, transfer mode, request remap) and then sets enable bits. Every change is screened against a cross-channel legality rule. A channel whose combined setting is not allowed never becomes enabled, and software can detect the refusal by reading the enable bit back as 0.

The block also decides which physical request line drives each channel. Channel A always follows slot A's first request line. Channel B normally follows slot B's request line. When its remap bit is set under a legal pairing, channel B follows slot A's second request line instead, so both channels serve slot A in opposite directions. The block's outputs are the gated per-channel requests handed to the data movers.

Top module: `dma_pair_arbiter`

## Requirements
- R1: After reset, both control registers and the enable register read 0, and both request outputs are 0.
- R2: Offset 0 holds channel A control and offset 1 holds channel B control. In each, bits [1:0] are the width (00 = 8 bits, 01 = 16 bits, 10 = 32 bits, 11 = reserved), bit 2 is the mode (0 = direct, 1 = chained) and bit 3 is the remap bit. Offset 2 holds the enables, with bit 0 for channel A and bit 1 for channel B. Offset 3 and all unassigned bits read 0, and read data is 0 while the read strobe is low.
- R3: A write to offset 2 sets each enable bit only when that channel's configuration is legal at that moment. A refused bit reads back 0, and the other channel's bit is decided independently.
- R4: A channel whose width field is 11 cannot be enabled.
- R5: With channel A at 8 or 16 bits and channel B's remap bit clear, channel B may be enabled in either mode at any non-reserved width.
- R6: With channel A at 32 bits in chained mode, channel B cannot be enabled.
- R7: With channel B's remap bit set, channel B can be enabled only when both channels are in direct mode and their width fields are equal.
- R8: A control write that makes an enabled channel illegal clears that channel's enable bit in the same edge. Channel A's enable depends only on its own width, so a conflict between the channels always clears channel B.
- R9: `dma_req_a` equals channel A's enable AND `slot_a_req[0]`. `dma_req_b` equals channel B's enable AND either `slot_a_req[1]` (remap bit set) or `slot_b_req` (remap bit clear).
- R10: In a cycle without a bus write, the enable bits do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (2) | Register offset |
| bus_wdata | input | DATA_W (4) | Write data |
| bus_rdata | output | DATA_W (4) | Read data (combinational) |
| slot_a_req | input | 2 | Slot A request lines, first in bit 0, second in bit 1 |
| slot_b_req | input | 1 | Slot B first request line |
| dma_req_a | output | 1 | Gated request to channel A |
| dma_req_b | output | 1 | Gated request to channel B |

## Verification
The assertions check three kinds of rule on every cycle. The first is the invariants of the stored state: no enabled channel with a reserved width, no enabled channel B under a 32-bit chained channel A, and no enabled remapped channel B without matching direct-mode settings. The second is that a refused enable never appears and that enables stay still without a write. The third is the gating and remap of the request outputs. Other behaviour shows only in the bench scenarios: the register layout and read-back values, the independence of the two enable bits in one write, the preference for clearing channel B when a later control write breaks the pairing, and the freedom channel B has when channel A is narrow.

// File: rtl/dma_pair_pkg.sv
package dma_pair_pkg;

  typedef enum logic [1:0] {
    WID_8   = 2'b00,
    WID_16  = 2'b01,
    WID_32  = 2'b10,
    WID_RSV = 2'b11
  } width_e;

  typedef enum logic {
    MODE_DIRECT  = 1'b0,
    MODE_CHAINED = 1'b1
  } mode_e;

  // bit 3 remap, bit 2 mode, bits 1:0 width
  typedef struct packed {
    logic   remap;
    mode_e  mode;
    width_e width;
  } chan_ctrl_t;

  localparam int CTRL_W = $bits(chan_ctrl_t);
  localparam int NCH    = 2;

  // Channel A may run whenever its own width is defined.
  function automatic logic chan_a_ok(chan_ctrl_t a);
    return a.width != WID_RSV;
  endfunction

  // Channel B depends on channel A's setting and its own remap request.
  function automatic logic chan_b_ok(chan_ctrl_t a, chan_ctrl_t b);
    logic a_blocks;
    logic pair_fits;
    a_blocks  = (a.width == WID_32) && (a.mode == MODE_CHAINED);
    pair_fits = (a.mode == MODE_DIRECT) && (b.mode == MODE_DIRECT) &&
                (a.width == b.width);
    return (b.width != WID_RSV) && !a_blocks && (!b.remap || pair_fits);
  endfunction

endpackage

// File: rtl/dma_pair_ctrl_regs.sv
module dma_pair_ctrl_regs
  import dma_pair_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [CTRL_W-1:0]        wdata,
  output chan_ctrl_t [NCH-1:0]     ctrl_q,
  output chan_ctrl_t [NCH-1:0]     ctrl_nxt
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic hit;
    assign hit          = wr && (addr == ADDR_W'(ch));
    assign ctrl_nxt[ch] = hit ? chan_ctrl_t'(wdata) : ctrl_q[ch];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[ch] <= '0;
      else        ctrl_q[ch] <= ctrl_nxt[ch];
    end
  end

endmodule

// File: rtl/dma_pair_enable.sv
module dma_pair_enable
  import dma_pair_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_wr,
  input  logic [NCH-1:0]       en_wdata,
  input  chan_ctrl_t [NCH-1:0] ctrl_nxt,
  output logic [NCH-1:0]       en_q,
  output logic [NCH-1:0]       en_refused,
  output logic [NCH-1:0]       en_revoked
);

  logic [NCH-1:0] legal;
  logic [NCH-1:0] en_base;
  logic [NCH-1:0] en_d;

  // legality is judged on the values the control registers will hold
  assign legal[0] = chan_a_ok(ctrl_nxt[0]);
  assign legal[1] = chan_b_ok(ctrl_nxt[0], ctrl_nxt[1]);

  assign en_base    = en_wr ? en_wdata : en_q;
  assign en_d       = en_base & legal;
  assign en_refused = en_wr  ? (en_wdata & ~legal) : '0;
  assign en_revoked = !en_wr ? (en_q & ~legal)     : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

endmodule

// File: rtl/dma_pair_router.sv
module dma_pair_router (
  input  logic       en_a,
  input  logic       en_b,
  input  logic       remap_b,
  input  logic [1:0] slot_a_req,
  input  logic       slot_b_req,
  output logic       dma_req_a,
  output logic       dma_req_b
);

  logic src_b;

  assign src_b     = remap_b ? slot_a_req[1] : slot_b_req;
  assign dma_req_a = en_a && slot_a_req[0];
  assign dma_req_b = en_b && src_b;

endmodule

// File: rtl/dma_pair_arbiter.sv
module dma_pair_arbiter
  import dma_pair_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        slot_a_req,
  input  logic              slot_b_req,
  output logic              dma_req_a,
  output logic              dma_req_b
);

  localparam logic [ADDR_W-1:0] OFS_EN = ADDR_W'(NCH);

  chan_ctrl_t [NCH-1:0] ctrl_q;
  chan_ctrl_t [NCH-1:0] ctrl_nxt;
  logic [NCH-1:0]       en_q;
  logic [NCH-1:0]       en_refused;
  logic [NCH-1:0]       en_revoked;
  logic                 en_wr;

  assign en_wr = bus_wr && (bus_addr == OFS_EN);

  dma_pair_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata[CTRL_W-1:0]),
    .ctrl_q   (ctrl_q),
    .ctrl_nxt (ctrl_nxt)
  );

  dma_pair_enable u_en (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_wr      (en_wr),
    .en_wdata   (bus_wdata[NCH-1:0]),
    .ctrl_nxt   (ctrl_nxt),
    .en_q       (en_q),
    .en_refused (en_refused),
    .en_revoked (en_revoked)
  );

  dma_pair_router u_route (
    .en_a       (en_q[0]),
    .en_b       (en_q[1]),
    .remap_b    (ctrl_q[1].remap),
    .slot_a_req (slot_a_req),
    .slot_b_req (slot_b_req),
    .dma_req_a  (dma_req_a),
    .dma_req_b  (dma_req_b)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr < OFS_EN)       bus_rdata = DATA_W'(ctrl_q[bus_addr[0]]);
      else if (bus_addr == OFS_EN) bus_rdata = DATA_W'(en_q);
    end
  end

endmodule

// File: rtl/dma_pair_arbiter_chk.sv
module dma_pair_arbiter_chk
  import dma_pair_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [1:0]           slot_a_req,
  input logic                 dma_req_a,
  input logic                 dma_req_b,
  input chan_ctrl_t [NCH-1:0] ctrl_q,
  input logic [NCH-1:0]       en_q,
  input logic [NCH-1:0]       en_refused
);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(en_q));

  p_rsv_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[0] |-> ctrl_q[0].width != WID_RSV);

  p_rsv_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[1] |-> ctrl_q[1].width != WID_RSV);

  p_block_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[1] |-> !(ctrl_q[0].width == WID_32 && ctrl_q[0].mode == MODE_CHAINED));

  p_remap_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[1] && ctrl_q[1].remap) |->
      (ctrl_q[0].mode == MODE_DIRECT && ctrl_q[1].mode == MODE_DIRECT &&
       ctrl_q[0].width == ctrl_q[1].width));

  p_refuse_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_refused[0] |=> !en_q[0]);

  p_refuse_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_refused[1] |=> !en_q[1]);

  p_drop_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q[1]) |-> $past(bus_wr));

  p_gate_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[0] |-> !dma_req_a);

  p_gate_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[1] |-> !dma_req_b);

  p_remap_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[1] && ctrl_q[1].remap) |-> dma_req_b == slot_a_req[1]);

endmodule

bind dma_pair_arbiter dma_pair_arbiter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .slot_a_req (slot_a_req),
  .dma_req_a  (dma_req_a),
  .dma_req_b  (dma_req_b),
  .ctrl_q     (ctrl_q),
  .en_q       (en_q),
  .en_refused (en_refused)
);

// File: tb/test_dma_pair_arbiter.sv
module test_dma_pair_arbiter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [3:0] bus_wdata = '0;
  logic [3:0] bus_rdata;
  logic [1:0] slot_a_req = '0;
  logic       slot_b_req = 1'b0;
  logic       dma_req_a;
  logic       dma_req_b;

  int checks = 0;
  int errors = 0;

  logic [3:0] m_ctrl [2];
  logic [1:0] m_en;

  always #10 clk = ~clk;

  dma_pair_arbiter i_dma_pair_arbiter (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_rd (bus_rd),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .slot_a_req (slot_a_req), .slot_b_req (slot_b_req),
    .dma_req_a (dma_req_a), .dma_req_b (dma_req_b)
  );

  // channel B rule, stated case by case
  function automatic bit b_allowed(logic [3:0] a, logic [3:0] b);
    if (b[1:0] == 2'b11) return 1'b0;
    if (a[1:0] == 2'b10 && a[2]) return 1'b0;
    if (b[3]) return (!a[2] && !b[2] && a[1:0] == b[1:0]);
    return 1'b1;
  endfunction

  function automatic logic [3:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return m_ctrl[0];
      2'd1: return m_ctrl[1];
      2'd2: return {2'b00, m_en};
      default: return 4'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a < 2) m_ctrl[a] = d;
    else if (a == 2) m_en = d[1:0];
    m_en = m_en & {b_allowed(m_ctrl[0], m_ctrl[1]), m_ctrl[0][1:0] != 2'b11};
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 4; a++) begin
      bus_rd = 1'b1; bus_addr = 2'(a); #1;
      check(tag, bus_rdata, exp_read(2'(a)));
    end
    bus_rd = 1'b0; bus_addr = 2'd0; #1;
    check("R2 strobe low", bus_rdata, 4'h0);
  endtask

  task automatic req_all(input string tag);
    for (int p = 0; p < 8; p++) begin
      logic eb;
      slot_a_req = p[1:0]; slot_b_req = p[2]; #1;
      eb = m_ctrl[1][3] ? p[1] : p[2];
      check(tag, {2'b00, dma_req_b, dma_req_a},
            {2'b00, m_en[1] & eb, m_en[0] & p[0]});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    m_ctrl[0] = '0; m_ctrl[1] = '0; m_en = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    bus_rd = 1'b1; bus_addr = 2'd0; #1; check("R1 ctrl A", bus_rdata, 4'h0);
    bus_addr = 2'd2; #1; check("R1 enable", bus_rdata, 4'h0);
    bus_rd = 1'b0;
    slot_a_req = 2'b11; slot_b_req = 1'b1; #1;
    check("R1 requests", {2'b00, dma_req_b, dma_req_a}, 4'h0);
    rst_n = 1'b1;
    read_all("R1 after release");

    // R6: A 32-bit chained blocks B, A still enables
    wr(0, 4'b0110); wr(1, 4'b0001); wr(2, 4'b0011);
    read_all("R6 block B"); check("R6 enable bits", exp_read(2), 4'b0001);

    // R5: A narrow, B 32 chained without remap
    wr(0, 4'b0101); wr(1, 4'b0110); wr(2, 4'b0011);
    read_all("R5 free B"); check("R5 enable bits", exp_read(2), 4'b0011);
    req_all("R9 normal routing");

    // R7: remap with matching direct widths
    wr(2, 4'b0000); wr(0, 4'b0001); wr(1, 4'b1001); wr(2, 4'b0011);
    read_all("R7 remap ok"); check("R7 enable bits", exp_read(2), 4'b0011);
    req_all("R9 remap routing");

    // R10: idle cycles leave enables
    repeat (5) @(negedge clk);
    read_all("R10 idle");

    // R8: width mismatch under remap drops B, keeps A
    wr(1, 4'b1010);
    read_all("R8 revoke"); check("R8 enable bits", exp_read(2), 4'b0001);

    // R7: mismatch refused
    wr(2, 4'b0011); read_all("R7 mismatch");

    // R4: reserved widths
    wr(0, 4'b0011); wr(1, 4'b0011); wr(2, 4'b0011);
    read_all("R4 reserved"); check("R4 enable bits", exp_read(2), 4'b0000);

    // R3: random mix of writes
    for (int i = 0; i < 1500; i++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 3));
      wr(a, 4'($urandom));
      read_all("R3 random");
      if (i % 8 == 0) req_all("R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule